// File: doc/BRIEF.md
# Selectable-Order Sinc Decimation Filter

This block turns a one-bit delta-sigma bitstream into decimated output words. A bit is accepted on every clock cycle in which the bit-clock enable is high. A two-bit mode input selects one of four functions: off, a second-order sinc filter, a third-order sinc filter, or a plain capture of the raw bitstream, 32 bits at a time.

In the two sinc modes, a chain of integrators advances on each accepted bit. Every integrator is 27 bits wide and wraps around silently. When a decimation period ends, the block takes the top integrator, runs it through as many differencing stages as the filter order, and right-justifies the result. All differences are taken in 27-bit modular arithmetic, so the wraparound of the integrators cancels out and no false high-order bits can reach the output.

The period is a power of two chosen by a four-bit code. A nonzero explicit count replaces it. A ready flag is raised with each new word and stays up until the word is acknowledged. A validity bit marks the first words after reset, while the differencing history is still filling.

Mode, code and explicit count are meant to be changed only while reset is asserted.

Top module: `sinc_decimator`

## Requirements
- R1: Mode encoding: 2'b01 selects second-order sinc, 2'b10 selects third-order sinc, 2'b11 selects raw capture and 2'b00 is off. When off, no word is produced and `sample_ready` stays low.
- R2: A bit clock is a cycle with `bit_en` high. In sinc modes the period is 2^`period_code` bit clocks (code 4'b0111 gives 128), unless `period_count` is nonzero, in which case it is `period_count` bit clocks. In raw mode the period is always 32 bit clocks.
- R3: On each bit clock the first integrator adds `bit_in` (0 or 1), and every later integrator adds the updated value of the one before it. All integrators are 27 bits wide and wrap modulo 2^27. Sinc2 uses two integrators and sinc3 uses three.
- R4: At the end of each period, the top integrator passes through `order` cascaded differencing stages (two for sinc2, three for sinc3). Each stage keeps its own previous input, and each difference is taken modulo 2^27. With an all-ones input, the output stays at full scale even after the integrators have wrapped.
- R5: The filtered value is zero-extended to 32 bits and shifted right before output. For sinc2 the shift is `period_code`-1 (0 when the code is 0); for sinc3 the shift is `period_code`. At code 7 with an all-ones input, the settled output is 256 for sinc2 and 16384 for sinc3.
- R6: In raw mode each bit enters at bit 31 while the register shifts right. After each group of 32 bit clocks, `sample` holds the group with its first bit in bit 0.
- R7: `sample` and `sample_ready` update on the clock edge that accepts the last bit of a period. The ready flag then stays high until a cycle with `rd_strobe` high. A `rd_strobe` in the same cycle as a period completion leaves the flag set.
- R8: `sample_valid` is 0 for the first word after reset in sinc2 and for the first two words in sinc3. It is 1 for all later words, and always 1 in raw mode.
- R9: `rst_n` low clears the integrators, the difference history, the counters, `sample`, `sample_ready` and `sample_valid` at once. Its release takes effect after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Function select (off, sinc2, sinc3, raw) |
| period_code | input | 4 | Power-of-two period exponent |
| period_count | input | 14 | Explicit period in bit clocks, 0 = use code |
| bit_en | input | 1 | Bit-clock enable |
| bit_in | input | 1 | Modulator bitstream |
| rd_strobe | input | 1 | Acknowledge of the current word |
| sample | output | 32 | Decimated or raw word |
| sample_ready | output | 1 | New word pending |
| sample_valid | output | 1 | Word is past the history fill |

## Verification
Every result of this block is due in the same place: the word, its validity bit and the ready flag all change on the edge that accepts the last bit of a period. They must appear one edge later when an acknowledge clears the flag. The bench drives each bit at a falling edge, advances its own model of the integrators, counters and flag at the following rising edge, and compares the outputs at the next falling edge. Each comparison therefore looks at a settled value exactly one register stage after the stimulus. The literal full-scale checks are taken once the run has ended on a period boundary, when `sample` is known to hold the last word.

// File: rtl/sinc_dec_pkg.sv
package sinc_dec_pkg;

  localparam int ORDER_MAX = 3;

  typedef enum logic [1:0] {
    FM_OFF   = 2'b00,
    FM_SINC2 = 2'b01,
    FM_SINC3 = 2'b10,
    FM_RAW   = 2'b11
  } fmode_e;

  // right-justification amount for a sinc mode and period exponent
  function automatic logic [4:0] just_shift(fmode_e m, logic [3:0] code);
    logic [4:0] s;
    if (m == FM_SINC3)      s = {1'b0, code};
    else if (code == 4'd0)  s = 5'd0;
    else                    s = {1'b0, code} - 5'd1;
    return s;
  endfunction

endpackage

// File: rtl/sinc_period_ctr.sv
module sinc_period_ctr #(
  parameter int CODE_W = 4,
  parameter int OVR_W  = 14,
  parameter int CNT_W  = 16,
  parameter int RAW_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              raw,
  input  logic [CODE_W-1:0] code,
  input  logic [OVR_W-1:0]  ovr,
  output logic              last
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, period_m1;

  always_comb begin
    if (raw)             period_m1 = CNT_W'(RAW_LEN - 1);
    else if (ovr != '0)  period_m1 = CNT_W'(ovr) - ONE;
    else                 period_m1 = (ONE << code) - ONE;
  end

  assign last = en && (cnt_q == period_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = last ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: position within the period never passes its end
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= period_m1);

  // R2: a completed period restarts the count
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> cnt_q == '0);

endmodule

// File: rtl/sinc_integ.sv
module sinc_integ #(
  parameter int W = 27,
  parameter int N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_i,
  output logic [N-1:0][W-1:0] nxt_o
);

  logic [N-1:0][W-1:0] acc_q;

  for (genvar k = 0; k < N; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign nxt_o[k] = acc_q[k] + {{(W-1){1'b0}}, bit_i};
    end else begin : g_rest
      assign nxt_o[k] = acc_q[k] + nxt_o[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc_q[k] <= '0;
      else if (en) acc_q[k] <= nxt_o[k];
    end
  end

  // R3: integrators advance only on bit clocks
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));

endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
  parameter int W = 27,
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [1:0]   order,
  input  logic [W-1:0] snap,
  output logic [W-1:0] result
);

  logic [N-1:0][W-1:0] dly_q;
  logic [N-1:0][W-1:0] stage_in;
  logic [N-1:0][W-1:0] diff;

  for (genvar k = 0; k < N; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign stage_in[k] = snap;
    end else begin : g_rest
      assign stage_in[k] = diff[k-1];
    end

    // W-bit subtraction is the modulo-2^W difference
    assign diff[k] = stage_in[k] - dly_q[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dly_q[k] <= '0;
      else if (take) dly_q[k] <= stage_in[k];
    end
  end

  assign result = diff[order - 2'd1];

  // R4: each snapshot becomes the first stage's history
  a_r4_history: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> dly_q[0] == $past(snap));

endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator
  import sinc_dec_pkg::*;
#(
  parameter int ACC_W  = 27,
  parameter int OUT_W  = 32,
  parameter int CODE_W = 4,
  parameter int OVR_W  = 14,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [CODE_W-1:0] period_code,
  input  logic [OVR_W-1:0]  period_count,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              rd_strobe,
  output logic [OUT_W-1:0]  sample,
  output logic              sample_ready,
  output logic              sample_valid
);

  localparam int PAD_W = OUT_W - ACC_W;

  fmode_e mode_e;
  assign mode_e = fmode_e'(mode);

  // reset: asserted at once, released after two edges
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic is_raw, is_sinc, active, done, take;
  assign is_raw  = (mode_e == FM_RAW);
  assign is_sinc = (mode_e == FM_SINC2) || (mode_e == FM_SINC3);
  assign active  = bit_en && (mode_e != FM_OFF);

  sinc_period_ctr #(.CODE_W(CODE_W), .OVR_W(OVR_W), .CNT_W(CNT_W), .RAW_LEN(OUT_W))
  i_ctr (
    .clk(clk), .rst_n(rst_int_n), .en(active), .raw(is_raw),
    .code(period_code), .ovr(period_count), .last(done)
  );

  logic [ORDER_MAX-1:0][ACC_W-1:0] integ_nxt;
  sinc_integ #(.W(ACC_W), .N(ORDER_MAX)) i_integ (
    .clk(clk), .rst_n(rst_int_n), .en(active && is_sinc),
    .bit_i(bit_in), .nxt_o(integ_nxt)
  );

  logic [1:0]       order;
  logic [ACC_W-1:0] snap, comb_out;
  assign order = (mode_e == FM_SINC3) ? 2'd3 : 2'd2;
  assign snap  = integ_nxt[order - 2'd1];
  assign take  = done && is_sinc;

  sinc_comb #(.W(ACC_W), .N(ORDER_MAX)) i_comb (
    .clk(clk), .rst_n(rst_int_n), .take(take), .order(order),
    .snap(snap), .result(comb_out)
  );

  // next state
  logic [OUT_W-1:0] shr_q, shr_d, sample_d;
  logic             ready_d, valid_d;
  logic [1:0]       nsamp_q, nsamp_d;

  always_comb begin
    shr_d    = shr_q;
    sample_d = sample;
    valid_d  = sample_valid;
    nsamp_d  = nsamp_q;
    ready_d  = sample_ready;
    if (active && is_raw) shr_d = {bit_in, shr_q[OUT_W-1:1]};
    if (done) begin
      ready_d = 1'b1;
      if (is_raw) begin
        sample_d = shr_d;
        valid_d  = 1'b1;
      end else begin
        sample_d = {{PAD_W{1'b0}}, comb_out} >> just_shift(mode_e, period_code);
        valid_d  = (nsamp_q >= order - 2'd1);
        if (nsamp_q != 2'd2) nsamp_d = nsamp_q + 2'd1;
      end
    end else if (rd_strobe) begin
      ready_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      shr_q        <= '0;
      sample       <= '0;
      sample_ready <= 1'b0;
      sample_valid <= 1'b0;
      nsamp_q      <= '0;
    end else begin
      shr_q        <= shr_d;
      sample       <= sample_d;
      sample_ready <= ready_d;
      sample_valid <= valid_d;
      nsamp_q      <= nsamp_d;
    end
  end

  // R7: pending word is kept until acknowledged
  a_r7_ready_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    sample_ready && !rd_strobe |=> sample_ready);

  // R7: acknowledge without a new completion drops the flag
  a_r7_ready_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    sample_ready && rd_strobe && !done |=> !sample_ready);

  // R1: off mode never raises ready
  a_r1_off_silent: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_e == FM_OFF) && !sample_ready |=> !sample_ready);

  // R8: raw words are always valid
  a_r8_raw_valid: assert property (@(posedge clk) disable iff (!rst_int_n)
    is_raw && done |=> sample_valid);

endmodule

// File: tb/test_sinc_decimator.sv
module test_sinc_decimator;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [3:0]  code;
  logic [13:0] ovr;
  logic        bit_en, bit_in, rd;
  logic [31:0] sample;
  logic        ready, valid;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  sinc_decimator i_sinc_decimator (
    .clk(clk), .rst_n(rst_n), .mode(mode), .period_code(code),
    .period_count(ovr), .bit_en(bit_en), .bit_in(bit_in), .rd_strobe(rd),
    .sample(sample), .sample_ready(ready), .sample_valid(valid)
  );

  // reference model state
  logic [26:0] mi [3];
  logic [26:0] md [3];
  logic [31:0] mshr;
  int          mcnt, msamp, ndone;
  logic        e_ready, e_valid;
  logic [31:0] e_sample;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin mi[k] = '0; md[k] = '0; end
    mshr = '0; mcnt = 0; msamp = 0; ndone = 0;
    e_ready = 1'b0; e_valid = 1'b0; e_sample = '0;
  endtask

  // one clock: drive at falling edge, model at rising edge, compare at falling edge
  task automatic step(input logic b, input logic e, input logic r);
    logic        fin;
    int          per, ord;
    logic [26:0] c, t;
    logic [4:0]  sh;
    bit_in = b; bit_en = e; rd = r;
    @(posedge clk);
    fin = 1'b0;
    if (e && mode == 2'b11) begin
      mshr = {b, mshr[31:1]};
      if (mcnt == 31) begin
        fin = 1'b1; mcnt = 0; e_sample = mshr; e_valid = 1'b1;
      end else mcnt++;
    end else if (e && (mode == 2'b01 || mode == 2'b10)) begin
      ord = (mode == 2'b10) ? 3 : 2;
      per = (ovr != 0) ? int'(ovr) : (1 << code);
      mi[0] = mi[0] + 27'(b);
      mi[1] = mi[1] + mi[0];
      mi[2] = mi[2] + mi[1];
      if (mcnt == per - 1) begin
        fin = 1'b1; mcnt = 0;
        c = mi[ord-1];
        for (int k = 0; k < ord; k++) begin
          t = c - md[k]; md[k] = c; c = t;
        end
        sh = (ord == 3) ? 5'(code) : ((code == 0) ? 5'd0 : 5'(code) - 5'd1);
        e_sample = {5'b0, c} >> sh;
        e_valid  = (msamp >= ord - 1);
        msamp++;
      end else mcnt++;
    end
    if (fin) begin e_ready = 1'b1; ndone++; end
    else if (r) e_ready = 1'b0;
    @(negedge clk);
    chk("R7 ready", {31'b0, ready}, {31'b0, e_ready});
    if (fin) begin
      chk((mode == 2'b11) ? "R6 raw word" : "R4 filtered word", sample, e_sample);
      chk("R8 valid", {31'b0, valid}, {31'b0, e_valid});
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [3:0] c, input logic [13:0] o);
    rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; rd = 1'b0;
    mode = m; code = c; ovr = o;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    repeat (3) step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic run_ones(input int periods, input logic r);
    int target;
    target = ndone + periods;
    while (ndone < target) step(1'b1, 1'b1, r);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; mode = 2'b01; code = 4'd7; ovr = '0;
    bit_en = 1'b0; bit_in = 1'b0; rd = 1'b0;
    repeat (3) @(negedge clk);
    // R9: outputs cleared while reset is low
    chk("R9 reset sample", sample, 32'h0);
    chk("R9 reset ready", {31'b0, ready}, 32'h0);
    chk("R9 reset valid", {31'b0, valid}, 32'h0);

    // R1: off mode produces nothing
    do_reset(2'b00, 4'd3, '0);
    repeat (200) step(1'b1, 1'b1, 1'b0);
    chk("R1 off no ready", {31'b0, ready}, 32'h0);

    // R5 / R8: sinc2, code 7, full scale
    do_reset(2'b01, 4'd7, '0);
    run_ones(1, 1'b0);
    chk("R8 sinc2 first invalid", {31'b0, valid}, 32'h0);
    run_ones(3, 1'b0);
    chk("R5 sinc2 full scale", sample, 32'd256);
    chk("R8 sinc2 later valid", {31'b0, valid}, 32'h1);

    // R3 / R4: sinc3, code 7, long enough for the integrators to wrap
    do_reset(2'b10, 4'd7, '0);
    run_ones(2, 1'b0);
    chk("R8 sinc3 second invalid", {31'b0, valid}, 32'h0);
    run_ones(12, 1'b0);
    chk("R4 sinc3 full scale after wrap", sample, 32'd16384);

    // R2: explicit count at the sinc2 limit, shift from code 13
    do_reset(2'b01, 4'd13, 14'd11585);
    run_ones(3, 1'b0);
    chk("R2 sinc2 explicit period", sample, 32'd134212225 >> 12);

    // R7: acknowledge held high through completions
    do_reset(2'b01, 4'd4, '0);
    run_ones(4, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    chk("R7 cleared by ack", {31'b0, ready}, 32'h0);

    // R6: raw capture with known words
    do_reset(2'b11, 4'd0, '0);
    for (int w = 0; w < 6; w++) begin
      logic [31:0] word;
      word = (w == 0) ? 32'h8000_0001 : $urandom;
      for (int i = 0; i < 32; i++) step(word[i], 1'b1, 1'b0);
      chk("R6 raw order", sample, word);
    end

    // constrained random: sinc modes, gapped bit clocks, random acks
    for (int n = 0; n < 8; n++) begin
      logic [1:0]  m;
      logic [3:0]  c;
      logic [13:0] o;
      int          dens, target;
      m = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
      c = 4'(3 + $urandom % 6);
      o = (m == 2'b01 && $urandom % 4 == 0) ? 14'(50 + $urandom % 400) : 14'd0;
      dens = $urandom % 101;
      do_reset(m, c, o);
      target = 5;
      while (ndone < target)
        step(($urandom % 100) < dens, ($urandom % 10) < 8, ($urandom % 10) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule